// File: doc/BRIEF.md
# Receive Descriptor Frame Writer

This block stores one received frame in host memory, under the control of a receive descriptor. Software hands the block a descriptor base address. The block reads the descriptor's status word at base + 4 and checks two things in it. The first is the completion flag, which shows whether the host has released the descriptor. The second is the implied-buffer flag. In normal mode the block then fetches a buffer address word and a buffer length word from the descriptor. In implied mode it skips that fetch and uses a fixed 1528-byte buffer that starts 8 bytes past the descriptor base.

Frame bytes come from a byte FIFO that marks the last byte of the frame. The block packs the bytes little-endian into 32-bit memory writes. A final partial word goes out with byte enables. If the frame is longer than the buffer, the bytes that fit are stored and the rest of the frame is drained and dropped. At the end the block writes the status word back with the completion flag set, an overflow flag when bytes were dropped, and the number of bytes it actually stored. Memory traffic uses a single-outstanding request/acknowledge port. Read data is valid in the cycle of the acknowledge.

Top module: `rx_desc_writer`

## Requirements
- R1: After `start` the first memory access is a read of base + 4. If bit 15 of that word is 1, the block performs no write and does not pop the FIFO. It reads base + 4 again after a fixed gap and continues once bit 15 reads 0.
- R2: When bit 28 of the status word is 0, the block reads the buffer address from base + 8 and the buffer length from bits 15:0 of the word at base + 12. Bits 31:16 of the length word are ignored.
- R3: When bit 28 of the status word is 1, the block reads neither base + 8 nor base + 12. It uses a 1528-byte buffer starting at base + 8.
- R4: Frame byte i is written to byte lane i mod 4 of the word at buffer address + 4·(i div 4). The buffer address is word aligned.
- R5: A final word holding fewer than 4 stored bytes is written with only the filled low lanes enabled. Memory bytes outside the stored range stay unchanged.
- R6: If the frame length exceeds the buffer length L, exactly the first L bytes are stored. When L is 0, no bytes are stored.
- R7: The status word written back to base + 4 has bit 15 = 1 and bit 24 = 1 exactly when bytes were dropped. Bits 12:0 hold the count of stored bytes. All other bits, bit 28 included, are 0.
- R8: `done` pulses high for one cycle, one cycle after the status write is acknowledged. `busy` is high from the cycle after `start` until then.
- R9: An unacknowledged memory request keeps `memReq` high with address, direction, data and enables unchanged.
- R10: Every byte of the frame, up to and including the one flagged last, is popped from the FIFO exactly once, whether it is stored or dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one frame using `descBase` (accepted when idle) |
| descBase | input | AW | Descriptor base byte address |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion pulse |
| fifoValid | input | 1 | FIFO holds a byte |
| fifoData | input | 8 | FIFO head byte |
| fifoLast | input | 1 | FIFO head byte is the last of the frame |
| fifoRead | output | 1 | Pop the FIFO head |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | AW | Byte address of the word |
| memWdata | output | 32 | Write data |
| memBe | output | 4 | Write byte enables |
| memAck | input | 1 | Request accepted. For reads, `memRdata` is valid now |
| memRdata | input | 32 | Read data |

## Verification
The hardest state to reach is a status word that still shows the descriptor as host-owned. The bench stores bit 15 set in the status word, lets the block poll for a while and counts the writes and FIFO pops that happen meanwhile. It then clears the bit from the memory model and checks that the frame completes normally. The other hard corner is truncation at the full 1528-byte implied buffer. The bench covers it with frames of 1527 to 1530 bytes. A sweep over every combination of short frame length and buffer length, including length 0, covers each partial-word lane and truncation point. Acknowledge and FIFO stalls are applied throughout.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;
  localparam int OWN_BIT  = 15;
  localparam int OVF_BIT  = 24;
  localparam int IMPL_BIT = 28;
  localparam int CNT_BITS = 13;
  localparam int IMPL_BUF_BYTES = 1528;
  localparam int IMPL_OFFSET = 8;

  typedef enum logic [1:0] {A_STAT, A_BADDR, A_BLEN, A_DATA} addr_sel_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_STAT, S_POLL, S_RD_ADDR, S_RD_LEN, S_XFER, S_WR_DATA, S_WR_STAT
  } state_t;

  typedef struct packed {
    logic      loadDesc;
    logic      loadStat;
    logic      loadAddr;
    logic      loadLen;
    logic      takeByte;
    logic      clearPack;
    addr_sel_t addrSel;
  } ctrl_t;
endpackage

// File: rtl/rxdw_path.sv
module rxdw_path
  import rxdw_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_t         ctrl,
  input  logic [AW-1:0] startAddr,
  input  logic [31:0]   memRdata,
  input  logic [7:0]    fifoData,
  input  logic          fifoLast,
  output logic          needFlush,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  output logic [3:0]    memBe
);
  localparam logic [LW-1:0] IMPL_LEN = LW'(IMPL_BUF_BYTES);

  logic [AW-1:0] descAddr, bufAddr;
  logic [LW-1:0] bufLen, count;
  logic [31:0]   packWord;
  logic [3:0]    packBe;
  logic          ovf;
  logic          fits;
  logic [1:0]    lane;
  logic [AW-1:0] wordOffs;
  logic [31:0]   statusWord;

  assign fits = count < bufLen;
  assign lane = count[1:0];
  assign needFlush = fits && (lane == 2'd3 || fifoLast || ({1'b0, count} + 1'b1) == {1'b0, bufLen});
  assign wordOffs = AW'(count - 1'b1) & ~AW'(3);

  always_comb begin
    statusWord = '0;
    statusWord[CNT_BITS-1:0] = CNT_BITS'(count);
    statusWord[OWN_BIT] = 1'b1;
    statusWord[OVF_BIT] = ovf;
  end

  always_comb begin
    unique case (ctrl.addrSel)
      A_STAT:  memAddr = descAddr + AW'(4);
      A_BADDR: memAddr = descAddr + AW'(8);
      A_BLEN:  memAddr = descAddr + AW'(12);
      default: memAddr = bufAddr + wordOffs;
    endcase
    memWdata = (ctrl.addrSel == A_DATA) ? packWord : statusWord;
    memBe    = (ctrl.addrSel == A_DATA) ? packBe : 4'hF;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAddr <= '0;
      bufAddr  <= '0;
      bufLen   <= '0;
      count    <= '0;
      packWord <= '0;
      packBe   <= '0;
      ovf      <= 1'b0;
    end else begin
      if (ctrl.loadDesc) begin
        descAddr <= startAddr;
        count    <= '0;
        packWord <= '0;
        packBe   <= '0;
        ovf      <= 1'b0;
      end
      if (ctrl.loadStat && memRdata[IMPL_BIT]) begin
        bufAddr <= descAddr + AW'(IMPL_OFFSET);
        bufLen  <= IMPL_LEN;
      end
      if (ctrl.loadAddr) bufAddr <= memRdata[AW-1:0];
      if (ctrl.loadLen)  bufLen  <= memRdata[LW-1:0];
      if (ctrl.takeByte) begin
        if (fits) begin
          packWord[lane*8 +: 8] <= fifoData;
          packBe[lane] <= 1'b1;
          count <= count + 1'b1;
        end else begin
          ovf <= 1'b1;
        end
      end
      if (ctrl.clearPack) begin
        packWord <= '0;
        packBe   <= '0;
      end
    end
  end

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= bufLen || $past(ctrl.loadLen) || $past(ctrl.loadStat));
  a_r5_be_low_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.addrSel == A_DATA && ctrl.clearPack) |->
      (packBe == 4'h1 || packBe == 4'h3 || packBe == 4'h7 || packBe == 4'hF));
endmodule

// File: rtl/rxdw_ctrl.sv
module rxdw_ctrl
  import rxdw_pkg::*;
#(
  parameter int POLL_GAP = 8
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  logic  ownedBit,
  input  logic  implBit,
  input  logic  fifoValid,
  input  logic  fifoLast,
  input  logic  needFlush,
  input  logic  memAck,
  output ctrl_t ctrl,
  output logic  memReq,
  output logic  memWe,
  output logic  fifoRead,
  output logic  busy,
  output logic  done
);
  localparam int PW = $clog2(POLL_GAP + 1);

  state_t state, nextState;
  logic [PW-1:0] pollCnt;
  logic lastPending;

  always_comb begin
    ctrl = '0;
    ctrl.addrSel = A_STAT;
    nextState = state;
    memReq = 1'b0;
    memWe = 1'b0;
    fifoRead = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        ctrl.loadDesc = 1'b1;
        nextState = S_RD_STAT;
      end
      S_RD_STAT: begin
        memReq = 1'b1;
        if (memAck) begin
          if (ownedBit) nextState = S_POLL;
          else begin
            ctrl.loadStat = 1'b1;
            nextState = implBit ? S_XFER : S_RD_ADDR;
          end
        end
      end
      S_POLL: if (pollCnt == PW'(POLL_GAP - 1)) nextState = S_RD_STAT;
      S_RD_ADDR: begin
        memReq = 1'b1;
        ctrl.addrSel = A_BADDR;
        ctrl.loadAddr = memAck;
        if (memAck) nextState = S_RD_LEN;
      end
      S_RD_LEN: begin
        memReq = 1'b1;
        ctrl.addrSel = A_BLEN;
        ctrl.loadLen = memAck;
        if (memAck) nextState = S_XFER;
      end
      S_XFER: begin
        ctrl.addrSel = A_DATA;
        fifoRead = fifoValid;
        ctrl.takeByte = fifoValid;
        if (fifoValid) begin
          if (needFlush) nextState = S_WR_DATA;
          else if (fifoLast) nextState = S_WR_STAT;
        end
      end
      S_WR_DATA: begin
        memReq = 1'b1;
        memWe = 1'b1;
        ctrl.addrSel = A_DATA;
        ctrl.clearPack = memAck;
        if (memAck) nextState = lastPending ? S_WR_STAT : S_XFER;
      end
      default: begin
        memReq = 1'b1;
        memWe = 1'b1;
        if (memAck) nextState = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      pollCnt <= '0;
      lastPending <= 1'b0;
      done <= 1'b0;
    end else begin
      state <= nextState;
      pollCnt <= (state == S_POLL) ? pollCnt + 1'b1 : '0;
      if (state == S_XFER && fifoValid) lastPending <= fifoLast;
      done <= (state == S_WR_STAT) && memAck;
    end
  end

  assign busy = (state != S_IDLE);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(ctrl.addrSel)));
  a_r1_owned_repoll: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RD_STAT && memAck && ownedBit) |=> (!memReq && !fifoRead));
  a_r8_done_after_status: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memReq && memWe && memAck && ctrl.addrSel == A_STAT));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_pop_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    (fifoRead && fifoLast) |=> !fifoRead);
endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer
  import rxdw_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int POLL_GAP = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [AW-1:0] descBase,
  output logic          busy,
  output logic          done,
  input  logic          fifoValid,
  input  logic [7:0]    fifoData,
  input  logic          fifoLast,
  output logic          fifoRead,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  output logic [3:0]    memBe,
  input  logic          memAck,
  input  logic [31:0]   memRdata
);
  ctrl_t ctrl;
  logic  needFlush;

  rxdw_ctrl #(.POLL_GAP(POLL_GAP)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .ownedBit(memRdata[OWN_BIT]), .implBit(memRdata[IMPL_BIT]),
    .fifoValid(fifoValid), .fifoLast(fifoLast), .needFlush(needFlush),
    .memAck(memAck), .ctrl(ctrl), .memReq(memReq), .memWe(memWe),
    .fifoRead(fifoRead), .busy(busy), .done(done)
  );

  rxdw_path #(.AW(AW), .LW(LW)) path_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .startAddr(descBase),
    .memRdata(memRdata), .fifoData(fifoData), .fifoLast(fifoLast),
    .needFlush(needFlush), .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe)
  );
endmodule

// File: tb/rx_desc_writer_tb_top.sv
module rx_desc_writer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 1'b0;
  logic [31:0] descBase = '0;
  logic busy, done, fifoRead, memReq, memWe;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [3:0] memBe;
  logic fifoValid, fifoLast, memAck;
  logic [7:0] fifoData;

  logic [31:0] mem [1024];
  int cyc = 0, idx = 0, frameLen = 0, seed = 0;
  int pops = 0, writes = 0, entryReads = 0, r9Viol = 0;
  int checks = 0, failures = 0;
  logic pendReq = 1'b0;
  logic [31:0] pendAddr = '0, pendData = '0;
  logic allDone = 1'b0;

  function automatic logic [7:0] fbyte(int i, int s);
    return 8'(i * 13 + s * 7 + 1);
  endfunction

  assign fifoValid = (idx < frameLen) && (cyc % 5 != 2);
  assign fifoData  = fbyte(idx, seed);
  assign fifoLast  = (idx == frameLen - 1);
  assign memAck    = memReq && (cyc % 3 != 1);
  assign memRdata  = mem[memAddr[11:2]];

  rx_desc_writer dut_i (
    .clk(clk), .rstN(rstN), .start(start), .descBase(descBase),
    .busy(busy), .done(done), .fifoValid(fifoValid), .fifoData(fifoData),
    .fifoLast(fifoLast), .fifoRead(fifoRead), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe), .memAck(memAck),
    .memRdata(memRdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fifoRead) begin idx <= idx + 1; pops <= pops + 1; end
    if (memReq && memAck && memWe) begin
      writes <= writes + 1;
      for (int b = 0; b < 4; b++)
        if (memBe[b]) mem[memAddr[11:2]][8*b +: 8] <= memWdata[8*b +: 8];
    end
    if (memReq && memAck && !memWe &&
        (memAddr == descBase + 8 || memAddr == descBase + 12))
      entryReads <= entryReads + 1;
    if (pendReq && (!memReq || memAddr != pendAddr || (memWe && memWdata != pendData)))
      r9Viol <= r9Viol + 1;
    pendReq <= memReq && !memAck;
    pendAddr <= memAddr;
    pendData <= memWdata;
  end

  task automatic check(string req, logic ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rdByte(int a);
    return mem[(a >> 2) & 1023][8*(a & 3) +: 8];
  endfunction

  task automatic runFrame(int desc, bit impl, int bAddr, int bLen, int fLen, int s, int ownCycles);
    int base, eff, stored, bad, guardBad, expStat;
    @(negedge clk);
    for (int w = 0; w < 1024; w++) mem[w] = 32'hA5A5A5A5;
    mem[(desc + 4) >> 2] = (impl ? 32'h1000_0000 : 32'h0) | (ownCycles > 0 ? 32'h8000 : 32'h0);
    if (!impl) begin
      mem[(desc + 8) >> 2] = bAddr;
      mem[(desc + 12) >> 2] = {16'hBEEF, 16'(bLen)};
    end
    base = impl ? desc + 8 : bAddr;
    eff  = impl ? 1528 : bLen;
    stored = (fLen < eff) ? fLen : eff;
    descBase = desc; seed = s; idx = 0; frameLen = fLen;
    pops = 0; writes = 0; entryReads = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 busy after start", busy, busy, 1);
    if (ownCycles > 0) begin
      repeat (ownCycles) @(negedge clk);
      // R1: descriptor still host-owned, nothing written or popped
      check("R1 no write while owned", writes == 0, writes, 0);
      check("R1 no pop while owned", pops == 0, pops, 0);
      mem[(desc + 4) >> 2] = impl ? 32'h1000_0000 : 32'h0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check("R8 done single pulse", !done && !busy, done, 0);
    check("R10 whole frame popped", pops == fLen, pops, fLen);
    bad = 0; guardBad = 0;
    for (int i = 0; i < stored; i++) if (rdByte(base + i) != fbyte(i, s)) bad++;
    for (int i = stored; i < stored + 8; i++) if (rdByte(base + i) != 8'hA5) guardBad++;
    check("R4 stored bytes", bad == 0, bad, 0);
    check("R5/R6 bytes past stored range untouched", guardBad == 0, guardBad, 0);
    expStat = 32'h8000 | stored | ((fLen > eff) ? 32'h0100_0000 : 0);
    check("R7 status word", mem[(desc + 4) >> 2] == expStat, mem[(desc + 4) >> 2], expStat);
    if (impl) check("R3 no buffer entry reads", entryReads == 0, entryReads, 0);
    else      check("R2 buffer entry reads", entryReads == 2, entryReads, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R8 reset idle", !busy && !done && !memReq && !fifoRead, {busy, done, memReq}, 0);
    rstN = 1'b1;
    for (int f = 1; f <= 9; f++)
      for (int b = 0; b <= 9; b++)
        runFrame(32'h40, 1'b0, 32'h800, b, f, f + b, 0);
    runFrame(32'h80, 1'b0, 32'h400, 20, 17, 3, 40);
    for (int f = 1527; f <= 1530; f++)
      runFrame(32'h100, 1'b1, 0, 0, f, f, 0);
    runFrame(32'h20, 1'b1, 0, 0, 6, 5, 25);
    check("R9 request held until ack", r9Viol == 0, r9Viol, 0);
    allDone = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!allDone) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule